// File: doc/BRIEF.md
# Snapshot-Read 64-bit Free-Running Counter

This block keeps a 64-bit count that advances by one on each asserted tick of a selected tick-enable input. The count is wider than the 32-bit register port, so software never reads the running value directly. It first asks the block to freeze a copy of all 64 bits into a holding register. It then polls the control register until the request bit drops, and only after that reads the two halves. Both halves come from one capture cycle, so a carry between the halves cannot tear the value.

The control register has three live bits: a source select, a self-clearing snapshot request and a self-clearing clear request. The request bit stays high for a short fixed time after the capture, which stands in for a synchronisation delay. The counter keeps running during a snapshot and during reads. A reset value parameter lets an integration, or a bench, start the count at a chosen point.

Top module: `snap_counter64`

## Requirements
- R1: While reset is asserted and after it is released, the control, low-word and high-word registers all read 0. The running count starts at the RST_COUNT parameter.
- R2: The count rises by exactly one on each clock edge at which the selected tick is high. Control bit 2 at 0 selects `tick_pri` and at 1 selects `tick_alt`. A new selection applies from the edge after the write that sets it.
- R3: The control register sits at offset 0xA0 and reads {bit 2 source select, bit 1 snapshot busy, bit 0 clear pending}, with all other bits 0. The low word is at 0xA4 and the high word at 0xA8. Any other offset reads 0.
- R4: Writing control bit 1 as 1 sets the busy bit. At the next clock edge all 64 bits of the running count are copied into the holding register in that single edge.
- R5: The busy bit reads 1 for exactly LATCH_DLY+1 cycles after the request write (3 with the default), and then reads 0.
- R6: The low and high words return the held snapshot and do not change until the next snapshot, however the counter moves in the meantime.
- R7: A snapshot request written while busy is already 1 neither restarts the busy time nor takes a second capture. Writing 0 to bit 1 or bit 0 cancels nothing.
- R8: Writing control bit 0 as 1 makes the clear bit read 1 for one cycle. At the following edge the count becomes 0 and any tick at that edge is lost. Counting resumes at the next tick.
- R9: The low word wraps from 0xFFFFFFFF to 0 with a carry into the high word, and the snapshot shows the carried value in both halves.
- R10: Every control write loads the source select from bit 2. A write that sets bit 1 or bit 0 while repeating the current bit 2 keeps the source unchanged.
- R11: When one write sets both bit 1 and bit 0, the snapshot holds the count from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_pri | input | 1 | Primary tick enable (source 0) |
| tick_alt | input | 1 | Alternate tick enable (source 1) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |

## Verification
Directed runs start the count just below the 32-bit boundary, so the snapshot must show the carry in both halves. Ticks are driven on the unselected source only, which separates a wrong source multiplexer from a dead counter. A clear is written with a tick at the same edge, which shows whether clear wins that edge. Combined snapshot-and-clear writes and repeated requests while busy show whether the capture is taken at the correct edge and whether busy can be restarted. A long random phase mixes ticks on both sources, control writes with random bit patterns and reads at mapped and unmapped offsets. Every read is compared with a cycle model built from the requirements.

// File: rtl/snap_cnt_pkg.sv
package snap_cnt_pkg;
  localparam int unsigned CTRL_CLR_BIT   = 0;
  localparam int unsigned CTRL_LATCH_BIT = 1;
  localparam int unsigned CTRL_SRC_BIT   = 2;
  localparam int unsigned CTRL_BITS      = 3;

  typedef struct packed {
    logic src;
    logic latch;
    logic clr;
  } ctrl_cmd_t;
endpackage

// File: rtl/snap_cnt_ctrl.sv
module snap_cnt_ctrl
  import snap_cnt_pkg::*;
#(
  parameter int unsigned LATCH_DLY = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_ctrl,
  input  ctrl_cmd_t cmd,
  output logic      src_sel,
  output logic      busy,
  output logic      clr_pend,
  output logic      snap_go
);
  localparam int unsigned WAIT_W = (LATCH_DLY < 1) ? 1 : $clog2(LATCH_DLY + 1);
  localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(LATCH_DLY);

  logic              src_q, src_d;
  logic              busy_q, busy_d;
  logic              clr_q, clr_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;

  always_comb begin
    src_d  = src_q;
    busy_d = busy_q;
    wcnt_d = wcnt_q;
    clr_d  = wr_ctrl && cmd.clr;
    if (wr_ctrl) src_d = cmd.src;
    if (busy_q) begin
      if (wcnt_q == WAIT_END) begin
        busy_d = 1'b0;
        wcnt_d = '0;
      end else begin
        wcnt_d = wcnt_q + 1'b1;
      end
    end else if (wr_ctrl && cmd.latch) begin
      busy_d = 1'b1;
      wcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      busy_q <= 1'b0;
      clr_q  <= 1'b0;
      wcnt_q <= '0;
    end else begin
      src_q  <= src_d;
      busy_q <= busy_d;
      clr_q  <= clr_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign src_sel  = src_q;
  assign busy     = busy_q;
  assign clr_pend = clr_q;
  assign snap_go  = busy_q && (wcnt_q == '0);

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wr_ctrl && cmd.latch));
  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(wcnt_q) == WAIT_END);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wcnt_q != WAIT_END) |=> busy_q);
  // R8
  clr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (!clr_q || $past(wr_ctrl)));
endmodule

// File: rtl/snap_cnt_core.sv
module snap_cnt_core #(
  parameter int unsigned    CNT_W     = 64,
  parameter int unsigned    SEG_W     = 16,
  parameter logic [CNT_W-1:0] RST_COUNT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_pri,
  input  logic             tick_alt,
  input  logic             src_sel,
  input  logic             clr_go,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int unsigned NSEG = CNT_W / SEG_W;

  logic            tick_sel;
  logic [NSEG-1:0] carry;

  assign tick_sel = src_sel ? tick_alt : tick_pri;
  assign carry[0] = tick_sel;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic [SEG_W-1:0] seg_q, seg_d;

    always_comb begin
      if (clr_go)        seg_d = '0;
      else if (carry[i]) seg_d = seg_q + 1'b1;
      else               seg_d = seg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q <= RST_COUNT[i*SEG_W +: SEG_W];
      else        seg_q <= seg_d;
    end

    assign cnt_q[i*SEG_W +: SEG_W] = seg_q;

    if (i + 1 < NSEG) begin : g_carry
      assign carry[i+1] = carry[i] & (&seg_q);
    end
  end

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_go |=> cnt_q == '0);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_go && !tick_sel) |=> $stable(cnt_q));
  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_go && tick_sel) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/snap_cnt_hold.sv
module snap_cnt_hold #(
  parameter int unsigned      CNT_W     = 64,
  parameter int unsigned      DATA_W    = 32,
  parameter int unsigned      ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'hA0,
  parameter logic [ADDR_W-1:0] ADDR_LO   = 8'hA4,
  parameter logic [ADDR_W-1:0] ADDR_HI   = 8'hA8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_go,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] ctrl_view,
  output logic [DATA_W-1:0] rdata
);
  logic [CNT_W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (snap_go) hold_d = cnt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: rdata = ctrl_view;
      ADDR_LO:   rdata = hold_q[DATA_W-1:0];
      ADDR_HI:   rdata = hold_q[CNT_W-1 -: DATA_W];
      default:   rdata = '0;
    endcase
  end

  // R4
  snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_go |=> hold_q == $past(cnt_in));
  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_go |=> $stable(hold_q));
endmodule

// File: rtl/snap_counter64.sv
module snap_counter64
  import snap_cnt_pkg::*;
#(
  parameter int unsigned       CNT_W     = 64,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       SEG_W     = 16,
  parameter int unsigned       LATCH_DLY = 2,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'hA0,
  parameter logic [ADDR_W-1:0] ADDR_LO   = 8'hA4,
  parameter logic [ADDR_W-1:0] ADDR_HI   = 8'hA8,
  parameter logic [CNT_W-1:0]  RST_COUNT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_pri,
  input  logic              tick_alt,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              wr_ctrl;
  ctrl_cmd_t         cmd;
  logic              src_sel, busy, clr_pend, snap_go;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] ctrl_view;
  logic              unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign wr_ctrl      = reg_we && (reg_addr == ADDR_CTRL);
  assign cmd          = '{src:   reg_wdata[CTRL_SRC_BIT],
                          latch: reg_wdata[CTRL_LATCH_BIT],
                          clr:   reg_wdata[CTRL_CLR_BIT]};
  assign unused_wdata = ^reg_wdata[DATA_W-1:CTRL_BITS];
  assign ctrl_view    = DATA_W'({src_sel, busy, clr_pend});

  snap_cnt_ctrl #(.LATCH_DLY(LATCH_DLY)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_ctrl  (wr_ctrl),
    .cmd      (cmd),
    .src_sel  (src_sel),
    .busy     (busy),
    .clr_pend (clr_pend),
    .snap_go  (snap_go)
  );

  snap_cnt_core #(.CNT_W(CNT_W), .SEG_W(SEG_W), .RST_COUNT(RST_COUNT)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_pri (tick_pri),
    .tick_alt (tick_alt),
    .src_sel  (src_sel),
    .clr_go   (clr_pend),
    .cnt_q    (cnt)
  );

  snap_cnt_hold #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ADDR_CTRL(ADDR_CTRL), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .snap_go   (snap_go),
    .cnt_in    (cnt),
    .reg_addr  (reg_addr),
    .ctrl_view (ctrl_view),
    .rdata     (reg_rdata)
  );

  // R3
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr == ADDR_CTRL) |-> reg_rdata[DATA_W-1:CTRL_BITS] == '0);
endmodule

// File: tb/snap_counter64_tb.sv
module snap_counter64_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          DLY        = 2;
  localparam logic [7:0]  A_CTRL     = 8'hA0;
  localparam logic [7:0]  A_LO       = 8'hA4;
  localparam logic [7:0]  A_HI       = 8'hA8;
  localparam logic [63:0] START      = 64'h0000_0000_FFFF_FFF0;

  logic        clk, rst_n, tick_pri, tick_alt, reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  int total, bad;

  snap_counter64 #(.LATCH_DLY(DLY), .RST_COUNT(START)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_pri(tick_pri), .tick_alt(tick_alt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // cycle model written from the requirements
  logic [63:0] m_cnt, m_hold;
  logic        m_src, m_busy, m_clr;
  int          m_wc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= START; m_hold <= '0; m_src <= 0; m_busy <= 0; m_clr <= 0; m_wc <= 0;
    end else begin
      logic wr;
      wr = reg_we && reg_addr == A_CTRL;
      if (m_clr) m_cnt <= '0;
      else if (m_src ? tick_alt : tick_pri) m_cnt <= m_cnt + 1;
      if (m_busy && m_wc == 0) m_hold <= m_cnt;
      if (m_busy) begin
        if (m_wc == DLY) begin m_busy <= 0; m_wc <= 0; end
        else m_wc <= m_wc + 1;
      end else if (wr && reg_wdata[1]) begin
        m_busy <= 1; m_wc <= 0;
      end
      m_clr <= wr && reg_wdata[0];
      if (wr) m_src <= reg_wdata[2];
    end
  end

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      A_CTRL:  return {29'd0, m_src, m_busy, m_clr};
      A_LO:    return m_hold[31:0];
      A_HI:    return m_hold[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic peek(logic [7:0] a, string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp_read(a));
  endtask

  task automatic step(logic we, logic [31:0] wd, logic tp, logic ta);
    reg_we = we; reg_addr = we ? A_CTRL : reg_addr; reg_wdata = wd;
    tick_pri = tp; tick_alt = ta;
    @(negedge clk);
    reg_we = 0; tick_pri = 0; tick_alt = 0;
  endtask

  task automatic wait_snap(output int n);
    n = 0;
    reg_addr = A_CTRL; #1;
    while (reg_rdata[1] && n < 20) begin
      n++;
      step(0, 0, 0, 0);
      reg_addr = A_CTRL; #1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL R5 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    total = 0; bad = 0;
    void'($urandom(32'd4242));
    rst_n = 0; tick_pri = 0; tick_alt = 0; reg_we = 0; reg_addr = A_CTRL; reg_wdata = 0;
    repeat (3) @(negedge clk);
    reg_addr = A_CTRL; #1; chk("R1 ctrl in reset", reg_rdata, 32'd0);
    reg_addr = A_LO;   #1; chk("R1 low in reset", reg_rdata, 32'd0);
    reg_addr = A_HI;   #1; chk("R1 high in reset", reg_rdata, 32'd0);
    rst_n = 1;
    repeat (4) step(0, 0, 0, 0);
    peek(A_CTRL, "R1 ctrl after release");

    // R9: 20 ticks from just below the 32-bit boundary
    repeat (20) step(0, 0, 1, 0);
    step(1, 32'h2, 0, 0);
    wait_snap(n);
    chk("R5 busy cycles", n, DLY + 1);
    reg_addr = A_LO; #1; chk("R9 low after wrap", reg_rdata, 32'h4);
    reg_addr = A_HI; #1; chk("R9 high carry", reg_rdata, 32'h1);

    // R6: held value stays while counter runs
    repeat (10) step(0, 0, 1, 0);
    reg_addr = A_LO; #1; chk("R6 low held", reg_rdata, 32'h4);
    peek(A_HI, "R6 high held");

    // R2: select alternate source, ticks on primary ignored
    step(1, 32'h4, 0, 0);
    repeat (5) step(0, 0, 1, 0);
    repeat (7) step(0, 0, 0, 1);
    step(1, 32'h6, 0, 0);
    wait_snap(n);
    reg_addr = A_LO; #1; chk("R2 alt source count", reg_rdata, 32'h15);
    reg_addr = A_CTRL; #1; chk("R10 source kept", reg_rdata, 32'h4);
    reg_addr = A_HI; #1; chk("R2 high", reg_rdata, 32'h1);

    // R8: clear with a tick at the clearing edge
    step(1, 32'h5, 0, 1);
    reg_addr = A_CTRL; #1; chk("R8 clear pending", reg_rdata, 32'h5);
    step(0, 0, 0, 1);
    reg_addr = A_CTRL; #1; chk("R8 clear self-cleared", reg_rdata, 32'h4);
    repeat (3) step(0, 0, 0, 1);
    step(1, 32'h6, 0, 0);
    wait_snap(n);
    reg_addr = A_LO; #1; chk("R8 count after clear", reg_rdata, 32'h3);
    reg_addr = A_HI; #1; chk("R8 high after clear", reg_rdata, 32'h0);

    // R11: snapshot and clear together
    step(1, 32'h7, 0, 0);
    wait_snap(n);
    reg_addr = A_LO; #1; chk("R11 pre-clear snapshot", reg_rdata, 32'h3);
    step(1, 32'h6, 0, 0);
    wait_snap(n);
    reg_addr = A_LO; #1; chk("R11 count cleared", reg_rdata, 32'h0);

    // R7: repeated request and zero write while busy
    repeat (2) step(0, 0, 0, 1);
    step(1, 32'h6, 0, 0);
    step(1, 32'h6, 0, 1);
    step(1, 32'h4, 0, 1);
    wait_snap(n);
    chk("R7 busy not restarted", n, DLY + 1 - 2);
    reg_addr = A_LO; #1; chk("R7 first capture kept", reg_rdata, 32'h2);

    // R3: unmapped offsets
    peek(8'h00, "R3 unmapped 00");
    peek(8'hAC, "R3 unmapped AC");
    peek(8'hA1, "R3 unmapped A1");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      logic [7:0]  a;
      r = $urandom;
      case (r[3:2])
        2'd0: a = A_CTRL;
        2'd1: a = A_LO;
        2'd2: a = A_HI;
        default: a = r[31:24];
      endcase
      peek(a, "R6 random read");
      step(r[7:5] == 3'd0, {29'd0, r[10:8]}, r[11], r[12]);
    end
    peek(A_CTRL, "R3 final ctrl");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule